// File: doc/BRIEF.md
# Presettable Cascaded Frequency Divider

This block divides its clock by a programmable ratio. A chain of equal-width binary counter stages, all on one clock, forms a single wide up counter. Each stage advances only when the stage below it is about to wrap, so the chain behaves like one binary counter whose carry travels from stage to stage as a count enable. The chain's terminal count goes high when every stage holds all ones. That one-clock pulse is the divided output.

The ratio comes from a parallel preset rather than from the counter's natural wrap. On the clock edge that follows a terminal count, every stage loads its slice of the preset together. The counter then runs from the preset up to all ones, so a preset P gives one output pulse every 2^16 - P input clocks. For example, a preset of 0x63C0 gives a pulse every 40,000 clocks.

Reset is asserted asynchronously and active-low, and it is released synchronously inside the block. Reset clears every stage to zero, so the first period after reset always spans the full 65,536 states. Later periods follow the preset.

Top module: `cascade_divider`

## Requirements
- R1: While reset is asserted, and until the internal release completes, the count output is 0x0000 and the terminal-count output is low.
- R2: When the terminal-count output is low, each clock edge raises the 16-bit count by exactly one.
- R3: A 4-bit stage changes only when every less significant stage holds 0xF, or when a load takes place. The carry out of the low nibble moves the count from 0x000F to 0x0010.
- R4: The terminal-count output is high exactly when the count is 0xFFFF.
- R5: On the clock edge that follows a cycle with terminal count high, the count takes the value the preset input held in that cycle.
- R6: With a steady preset P, consecutive terminal-count pulses are 65,536 - P clocks apart. Examples: 40,000 clocks for 0x63C0, 16 clocks for 0xFFF0, and 2 clocks for 0xFFFE.
- R7: With a preset of 0xFFFF, the terminal-count output stays high on every clock and the count holds at 0xFFFF.
- R8: The preset is used only at a load. Changing it in the middle of a period leaves the length of that period unchanged.
- R9: After reset, the first terminal-count pulse comes 65,534 clocks after the first clock at which the count reads 0x0001. That pulse ends a first period of 65,536 states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Common clock for all stages |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| preset_i | input | 16 | Value loaded into the chain after each terminal count |
| count_o | output | 16 | Current counter value |
| tc_o | output | 1 | Terminal-count pulse, which is the divided clock |

## Verification
The assertions check the local rules on every cycle:
- the single-step increment whenever no terminal count is present;
- a stage holding while its enable and load are both low;
- the terminal-count decode matching an all-ones count;
- the load of the preset on the edge after a terminal count.

Only the bench's scenarios can show the long-range properties. These are the spacing between pulses for several presets, the full first period after reset, the continuous output for a preset of 0xFFFF, and the fact that a preset changed mid-period takes effect only at the next load.

// File: rtl/div_pkg.sv
package div_pkg;
  // Default width of one counter stage.
  localparam int unsigned DIV_STAGE_W    = 4;
  // Default number of cascaded stages.
  localparam int unsigned DIV_N_STAGES   = 4;
  // Default number of flops in the reset-release synchronizer.
  localparam int unsigned DIV_SYNC_DEPTH = 2;
endpackage

// File: rtl/div_rst_sync.sv
module div_rst_sync #(
  parameter int unsigned DEPTH = div_pkg::DIV_SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  // Shift ones in from the bottom once reset is released.
  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[DEPTH-1];
endmodule

// File: rtl/div_stage.sv
module div_stage #(
  parameter int unsigned W = div_pkg::DIV_STAGE_W
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [W-1:0] preset_i,
  output logic [W-1:0] q_o,
  output logic         tc_o
);
  logic [W-1:0] q_q;
  logic [W-1:0] q_d;

  // Next state: a load wins over counting.
  always_comb begin
    q_d = q_q;
    if (load_i)    q_d = preset_i;
    else if (en_i) q_d = q_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) q_q <= '0;
    else          q_q <= q_d;
  end

  assign q_o  = q_q;
  assign tc_o = en_i && (q_q == {W{1'b1}});

  // R3: a stage with no enable and no load keeps its value.
  a_r3_stage_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!en_i && !load_i) |=> $stable(q_q));
endmodule

// File: rtl/cascade_divider.sv
module cascade_divider #(
  parameter int unsigned STAGE_W    = div_pkg::DIV_STAGE_W,
  parameter int unsigned N_STAGES   = div_pkg::DIV_N_STAGES,
  parameter int unsigned SYNC_DEPTH = div_pkg::DIV_SYNC_DEPTH
) (
  input  logic                          clk_i,
  input  logic                          rst_n_i,
  input  logic [STAGE_W*N_STAGES-1:0]   preset_i,
  output logic [STAGE_W*N_STAGES-1:0]   count_o,
  output logic                          tc_o
);
  localparam int unsigned TOT_W = STAGE_W * N_STAGES;

  logic                rst_sync_n;
  logic [N_STAGES:0]   stage_en;
  logic [N_STAGES-1:0] stage_tc;
  logic                chain_load;

  div_rst_sync #(.DEPTH(SYNC_DEPTH)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_n_i(rst_n_i),
    .rst_n_o(rst_sync_n)
  );

  // The lowest stage counts on every clock.
  assign stage_en[0] = 1'b1;

  // Each stage's terminal count becomes the enable of the stage above it.
  for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
    div_stage #(.W(STAGE_W)) u_stage (
      .clk_i   (clk_i),
      .rst_n_i (rst_sync_n),
      .en_i    (stage_en[i]),
      .load_i  (chain_load),
      .preset_i(preset_i[i*STAGE_W +: STAGE_W]),
      .q_o     (count_o[i*STAGE_W +: STAGE_W]),
      .tc_o    (stage_tc[i])
    );
    assign stage_en[i+1] = stage_tc[i];
  end

  // The chain's terminal count is the divided output, and it loads the
  // preset on the next edge.
  assign chain_load = stage_en[N_STAGES];
  assign tc_o       = chain_load;

  // R2: with no terminal count, the count advances by one.
  a_r2_increment: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !tc_o |=> (count_o == TOT_W'($past(count_o) + TOT_W'(1))));

  // R4: the terminal count matches an all-ones count.
  a_r4_tc_all_ones: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    tc_o == (&count_o));

  // R5: the edge after a terminal count loads the preset.
  a_r5_load: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    tc_o |=> (count_o == $past(preset_i)));
endmodule

// File: tb/cascade_divider_tb_top.sv
module cascade_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] preset;
  wire  [15:0] count;
  wire         tc;

  int cyc    = 0;
  int n_chk  = 0;
  int n_fail = 0;
  int c1     = 0;
  int last   = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cascade_divider dut_i (
    .clk_i   (clk),
    .rst_n_i (rst_n),
    .preset_i(preset),
    .count_o (count),
    .tc_o    (tc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_tc(output int at);
    do @(negedge clk); while (!tc);
    at = cyc;
  endtask

  task automatic t_reset;
    rst_n  = 1'b0;
    preset = 16'h63C0;
    repeat (3) @(negedge clk);
    check("R1 count in reset", count, 16'h0000);
    check("R1 tc in reset", tc, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 count during release", count, 16'h0000);
  endtask

  task automatic t_count_carry;
    do @(negedge clk); while (count != 16'h0001);
    c1 = cyc;
    for (int k = 2; k <= 18; k++) begin
      @(negedge clk);
      check("R2 step", count, k);
      if (k == 16) check("R3 carry into second stage", count[15:4], 12'h001);
    end
  endtask

  task automatic t_first_period;
    int a;
    wait_tc(a);
    check("R9 first pulse position", a - c1, 65534);
    check("R4 count at pulse", count, 16'hFFFF);
    @(negedge clk);
    check("R5 preset loaded", count, 16'h63C0);
    check("R4 tc low after load", tc, 1'b0);
    last = a;
  endtask

  task automatic t_ratio;
    int b;
    wait_tc(b);
    check("R6 interval for 0x63C0", b - last, 40000);
    last = b;
  endtask

  task automatic t_midperiod;
    int b;
    repeat (100) @(negedge clk);
    preset = 16'hFFF0;
    wait_tc(b);
    check("R8 period unchanged by mid-period preset", b - last, 40000);
    last = b;
    wait_tc(b);
    check("R6 interval for 0xFFF0", b - last, 16);
    last = b;
  endtask

  task automatic t_hold;
    // Set at the pulse's negedge, so the next edge loads 0xFFFF.
    preset = 16'hFFFF;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R7 tc held high", tc, 1'b1);
      check("R7 count held", count, 16'hFFFF);
    end
  endtask

  task automatic t_short_and_zero;
    preset = 16'hFFFE;
    @(negedge clk);
    check("R6 period-2 low phase count", count, 16'hFFFE);
    check("R6 period-2 low phase tc", tc, 1'b0);
    @(negedge clk);
    check("R6 period-2 high phase tc", tc, 1'b1);
    preset = 16'h0000;
    @(negedge clk);
    check("R5 zero preset loaded", count, 16'h0000);
    check("R4 tc low at zero", tc, 1'b0);
    @(negedge clk);
    check("R2 step after zero load", count, 16'h0001);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (R6 R9): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_count_carry();
    t_first_period();
    t_ratio();
    t_midperiod();
    t_hold();
    t_short_and_zero();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule